// File: doc/BRIEF.md
# I2C Master Command-Word Transaction Engine

This block carries out one complete I2C master transaction from a single 32-bit command word. The word selects read or write, 7-bit or 10-bit addressing, the number of payload bytes and whether the transaction closes with a stop condition or leaves the bus held so that a repeated start can follow. Outgoing payload bytes are pulled from a transmit byte stream and incoming bytes are pushed to a receive byte stream, both with valid/ready handshakes. While it waits on either stream, the engine holds SCL low.

Bus timing comes from an external `tick` strobe. Every bit and every start or stop condition takes four ticks. SCL is high during the second and third of these ticks, and the engine samples SDA on the tick that ends the third. The lines are open-drain: a 1 on `sda_o` or `scl_o` releases the line, and `sda_i` returns the resolved SDA level. A status word reports the operation, the state, an abort cause and the number of bytes moved. Three one-cycle pulses report completion with a stop, completion without a stop, and an abort.

Top module: `i2ccw_engine`

## Requirements
- R1: The command word is decoded as follows. Bit 0 selects read (1) or write (0). Bits 7:1 hold a 7-bit address, or bits 6:0 of a 10-bit address. Bits 10:8 hold address bits 9:7. Bits 13:12 equal to 2 select 10-bit mode, and any other value selects 7-bit mode. Bit 14 requests a stop. Bits 25:15 give the byte length. Bit 11 (start-byte request) has no effect.
- R2: In 7-bit mode the first byte after the start is {address[6:0], rw}, sent MSB first. The ninth SCL pulse of each master-sent byte leaves SDA released so that the slave can ACK by pulling the line low.
- R3: In 10-bit mode the engine sends {11110, A[9:8], 0} and then A[7:0]. For a read it then issues a repeated start followed by {11110, A[9:8], 1}.
- R4: A start drives SDA from high to low while SCL is high. A stop drives SDA from low to high while SCL is high. At all other times SDA changes only while SCL is low, and each bit gives exactly one SCL high pulse lasting two ticks.
- R5: `tx_ready` is high only while the engine waits for the next write byte. Exactly `length` bytes are taken from the stream, and each is sent MSB first.
- R6: On a read, each byte is shifted in MSB first and presented on `rx_data` with `rx_valid`, which is held until `rx_ready`. The master ACKs (SDA low) every byte except the last and NACKs (SDA released) the last.
- R7: With bit 14 set, the engine ends with a stop and pulses `done_stop`. With bit 14 clear, it pulses `done_nostop`, holds SCL low and releases SDA. The next command then begins with a repeated start.
- R8: If the address is NACKed, the engine sends a stop and aborts with cause 0. If a write data byte is NACKed, it sends a stop and aborts with cause 1, and the count equals the number of ACKed bytes.
- R9: If SDA is released high on a master-driven bit but sampled low, arbitration is lost. The engine releases both lines at once, sends no stop, and aborts with cause 3.
- R10: The status word is laid out as follows: bits 1:0 = {0, rw}; bits 3:2 = state (0 idle, 1 ongoing, 2 ok, 3 abort); bits 6:4 = abort cause; bits 19:9 = bytes transferred. All other bits are 0. Cause codes 2, 4, 5 and 6 are reserved and are never produced.
- R11: `cmd_ready` is high only while the engine is idle, and a command is accepted only then.
- R12: A length of 0 produces only the start, the address phase and the chosen ending, with count 0.
- R13: `done_stop`, `done_nostop` and `abort_o` are one-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bus phase strobe, one per quarter bit |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 32 | Transaction command word |
| cmd_ready | output | 1 | Engine idle, command accepted |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Engine takes transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Receiver takes byte |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| sda_i | input | 1 | Resolved SDA line level |
| status | output | 32 | Status word |
| done_stop | output | 1 | Completed with stop |
| done_nostop | output | 1 | Completed without stop |
| abort_o | output | 1 | Transaction aborted |

## Verification
The hardest situations to reach are lost arbitration and a 10-bit read, because each depends on the slave side answering at one particular bit. The bench builds every transaction's expected SDA levels, pulse by pulse, from the command fields. A slave model that queues its line pulls pulse by pulse runs beside it, so a NACK can be placed on any chosen byte and a competing low on any chosen address bit. The master's SDA is then compared on every clock while SCL is high.

// File: rtl/i2ccw_pkg.sv
package i2ccw_pkg;
  localparam int LEN_W  = 11;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 32;
  localparam int STAT_W = 32;
  localparam int ADR_W  = 10;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_SEND, S_RECV, S_TXW, S_RXP, S_STOP
  } st_t;

  typedef enum logic [1:0] {
    X_IDLE = 2'd0, X_BUSY = 2'd1, X_OK = 2'd2, X_ABORT = 2'd3
  } xs_t;

  localparam logic [2:0] AB_ADDR_NACK = 3'd0;
  localparam logic [2:0] AB_DATA_NACK = 3'd1;
  localparam logic [2:0] AB_ARB       = 3'd3;

  typedef struct packed {
    logic             rd;
    logic             ten;
    logic             stop;
    logic [ADR_W-1:0] adr;
    logic [LEN_W-1:0] len;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] w);
    cmd_t d;
    d.rd   = w[0];
    d.ten  = (w[13:12] == 2'd2);
    d.stop = w[14];
    d.adr  = {w[10:8], w[7:1]};
    d.len  = w[25:15];
    return d;
  endfunction

  // step 0: first header, 1: 10-bit low byte, 2: 10-bit read header
  function automatic logic [BYTE_W-1:0] hdr_byte(input cmd_t c, input logic [1:0] step);
    case (step)
      2'd0:    return c.ten ? {5'b11110, c.adr[9:8], 1'b0} : {c.adr[6:0], c.rd};
      2'd1:    return c.adr[7:0];
      default: return {5'b11110, c.adr[9:8], 1'b1};
    endcase
  endfunction

  function automatic st_t after_byte(input cmd_t c, input logic more);
    if (more)        return c.rd ? S_RECV : S_TXW;
    else if (c.stop) return S_STOP;
    else             return S_IDLE;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input xs_t xs, input logic [2:0] cause,
                                                    input logic rd, input logic [LEN_W-1:0] cnt);
    return {12'd0, cnt, 2'b00, cause, xs, 1'b0, rd};
  endfunction
endpackage

// File: rtl/i2ccw_linedrv.sv
module i2ccw_linedrv
  import i2ccw_pkg::*;
(
  input  st_t        st,
  input  logic [1:0] ph,
  input  logic       bit_ack,
  input  logic       sh_msb,
  input  logic       rd_last,
  input  logic       parked,
  output logic       scl_o,
  output logic       sda_o
);
  logic ph_high;
  assign ph_high = (ph == 2'd1) || (ph == 2'd2);

  always_comb begin
    scl_o = 1'b0;
    sda_o = 1'b1;
    case (st)
      S_IDLE:  begin scl_o = ~parked; sda_o = 1'b1; end
      S_START: begin scl_o = ph_high; sda_o = (ph < 2'd2); end
      S_SEND:  begin scl_o = ph_high; sda_o = bit_ack ? 1'b1 : sh_msb; end
      S_RECV:  begin scl_o = ph_high; sda_o = bit_ack ? rd_last : 1'b1; end
      S_STOP:  begin scl_o = (ph != 2'd0); sda_o = (ph >= 2'd2); end
      default: begin scl_o = 1'b0; sda_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/i2ccw_ctrl.sv
module i2ccw_ctrl
  import i2ccw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_ready,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              rx_ready,
  input  logic              sda_i,
  output st_t               st,
  output logic [1:0]        ph,
  output logic              bit_ack,
  output logic              sh_msb,
  output logic              rd_last,
  output logic              parked,
  output logic [LEN_W-1:0]  cur_len,
  output logic [STAT_W-1:0] status,
  output logic              done_stop,
  output logic              done_nostop,
  output logic              abort_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  cmd_t              c;
  logic [3:0]        bitc;
  logic [BYTE_W-1:0] sh;
  logic [1:0]        hstep;
  logic              in_addr, ab, ackok;
  logic [LEN_W-1:0]  cnt;
  logic [2:0]        cause;
  xs_t               xs;

  logic more_now, more_inc, arb_lost, go_more;
  assign more_now = (cnt != c.len);
  assign more_inc = ((cnt + ONE) != c.len);
  assign go_more  = in_addr ? more_now : more_inc;
  assign arb_lost = (st == S_SEND) && tick && (ph == 2'd2) && (bitc != 4'd8) && sh[BYTE_W-1] && !sda_i;

  assign cmd_ready = (st == S_IDLE);
  assign tx_ready  = (st == S_TXW);
  assign rx_valid  = (st == S_RXP);
  assign rx_data   = sh;
  assign bit_ack   = (bitc == 4'd8);
  assign sh_msb    = sh[BYTE_W-1];
  assign rd_last   = !more_inc;
  assign cur_len   = c.len;
  assign status    = pack_status(xs, cause, c.rd, cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 2'd0; bitc <= 4'd0; sh <= '0; c <= '0; hstep <= 2'd0;
      in_addr <= 1'b0; ab <= 1'b0; ackok <= 1'b0; cnt <= '0; cause <= 3'd0;
      xs <= X_IDLE; parked <= 1'b0;
      done_stop <= 1'b0; done_nostop <= 1'b0; abort_o <= 1'b0;
    end else begin
      done_stop <= 1'b0; done_nostop <= 1'b0; abort_o <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          c <= decode_cmd(cmd_word); st <= S_START; ph <= 2'd0; hstep <= 2'd0;
          cnt <= '0; cause <= 3'd0; xs <= X_BUSY; ab <= 1'b0;
        end
        S_START: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            st <= S_SEND; bitc <= 4'd0; sh <= hdr_byte(c, hstep); in_addr <= 1'b1;
          end
        end
        S_SEND: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd2 && bitc == 4'd8) ackok <= !sda_i;
          if (ph == 2'd3) begin
            if (bitc != 4'd8) begin
              sh <= {sh[BYTE_W-2:0], 1'b0}; bitc <= bitc + 4'd1;
            end else begin
              bitc <= 4'd0;
              if (!ackok) begin
                st <= S_STOP; ab <= 1'b1; cause <= in_addr ? AB_ADDR_NACK : AB_DATA_NACK;
              end else if (in_addr && c.ten && hstep == 2'd0) begin
                hstep <= 2'd1; sh <= hdr_byte(c, 2'd1);
              end else if (in_addr && c.ten && hstep == 2'd1 && c.rd) begin
                hstep <= 2'd2; st <= S_START;
              end else begin
                in_addr <= 1'b0;
                if (!in_addr) cnt <= cnt + ONE;
                st <= after_byte(c, go_more);
                if (!go_more && !c.stop) begin
                  xs <= X_OK; done_nostop <= 1'b1; parked <= 1'b1;
                end
              end
            end
          end
          if (arb_lost) begin
            st <= S_IDLE; ph <= 2'd0; xs <= X_ABORT; cause <= AB_ARB;
            abort_o <= 1'b1; parked <= 1'b0;
          end
        end
        S_TXW: if (tx_valid) begin
          sh <= tx_data; st <= S_SEND; bitc <= 4'd0;
        end
        S_RECV: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd2 && bitc != 4'd8) sh <= {sh[BYTE_W-2:0], sda_i};
          if (ph == 2'd3) begin
            if (bitc != 4'd8) bitc <= bitc + 4'd1;
            else begin bitc <= 4'd0; st <= S_RXP; end
          end
        end
        S_RXP: if (rx_ready) begin
          cnt <= cnt + ONE;
          st <= after_byte(c, more_inc);
          if (!more_inc && !c.stop) begin
            xs <= X_OK; done_nostop <= 1'b1; parked <= 1'b1;
          end
        end
        S_STOP: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            st <= S_IDLE; parked <= 1'b0;
            if (ab) begin xs <= X_ABORT; abort_o <= 1'b1; end
            else begin xs <= X_OK; done_stop <= 1'b1; end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2ccw_engine.sv
module i2ccw_engine
  import i2ccw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_ready,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i,
  output logic [STAT_W-1:0] status,
  output logic              done_stop,
  output logic              done_nostop,
  output logic              abort_o
);
  st_t              st_w;
  logic [1:0]       ph_w;
  logic             bit_ack_w, sh_msb_w, rd_last_w, parked_w;
  logic [LEN_W-1:0] len_w;

  i2ccw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .sda_i(sda_i), .st(st_w), .ph(ph_w), .bit_ack(bit_ack_w), .sh_msb(sh_msb_w),
    .rd_last(rd_last_w), .parked(parked_w), .cur_len(len_w), .status(status),
    .done_stop(done_stop), .done_nostop(done_nostop), .abort_o(abort_o)
  );

  i2ccw_linedrv u_line (
    .st(st_w), .ph(ph_w), .bit_ack(bit_ack_w), .sh_msb(sh_msb_w),
    .rd_last(rd_last_w), .parked(parked_w), .scl_o(scl_o), .sda_o(sda_o)
  );
endmodule

// File: rtl/i2ccw_chk.sv
module i2ccw_chk
  import i2ccw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_o,
  input logic              sda_o,
  input st_t               st,
  input logic              cmd_ready,
  input logic              done_stop,
  input logic              done_nostop,
  input logic              abort_o,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [BYTE_W-1:0] rx_data,
  input logic [STAT_W-1:0] status,
  input logic [LEN_W-1:0]  len
);
  // R4
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && st != S_START && st != S_STOP) |-> (sda_o == $past(sda_o)));

  // R13
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done_stop, done_nostop, abort_o}) <= 1);

  // R13
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_stop || done_nostop || abort_o) |=> !(done_stop || done_nostop || abort_o));

  // R11
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'd1) |-> !cmd_ready);

  // R5
  stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready && rx_valid));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[19:9] <= len);

  // R7
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_nostop |-> (!scl_o && sda_o));

  // R9
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o && status[6:4] == 3'd3) |-> (scl_o && sda_o));
endmodule

bind i2ccw_engine i2ccw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_o(sda_o), .st(st_w),
  .cmd_ready(cmd_ready), .done_stop(done_stop), .done_nostop(done_nostop),
  .abort_o(abort_o), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .status(status), .len(len_w)
);

// File: tb/sim_i2ccw_engine.sv
module sim_i2ccw_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        cmd_ready;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready = 1'b1;
  logic        scl_o, sda_o;
  logic        slave_bit = 1'b1;
  wire         sda_i = sda_o & slave_bit;
  logic [31:0] status;
  logic        done_stop, done_nostop, abort_o;

  i2ccw_engine u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_ready(cmd_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .scl_o(scl_o),
    .sda_o(sda_o), .sda_i(sda_i), .status(status), .done_stop(done_stop),
    .done_nostop(done_nostop), .abort_o(abort_o)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  logic [1:0] exp_q[$];   // per SCL pulse: {sda first high tick, sda second high tick}
  logic       slv_q[$];   // per SCL pulse: slave pull (0 = low)
  logic [7:0] txq[$];
  logic [7:0] got_q[$];
  logic [1:0] cur = 2'b11;
  int         hc = 8;
  logic       prev_scl = 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv, input string what);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // phase strobe every fourth clock
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tick = (tc == 3);
      tc = (tc + 1) % 4;
    end
  end

  // streams and per-clock line comparison
  initial begin
    forever begin
      @(negedge clk);
      if (tx_ready && txq.size() != 0) begin
        tx_data = txq.pop_front(); tx_valid = 1'b1;
      end else begin
        tx_valid = (txq.size() != 0);
        tx_data  = (txq.size() != 0) ? txq[0] : 8'h00;
      end
      if (rx_valid) got_q.push_back(rx_data);
      if (rst_n) begin
        if (scl_o && !prev_scl) begin
          if (exp_q.size() == 0) begin
            chk("R4", 32'd1, 32'd0, "unexpected SCL pulse");
            cur = 2'b11; slave_bit = 1'b1;
          end else begin
            cur = exp_q.pop_front();
            slave_bit = (slv_q.size() != 0) ? slv_q.pop_front() : 1'b1;
          end
          hc = 0;
        end
        if (!scl_o && prev_scl) slave_bit = 1'b1;
        if (scl_o) begin
          chk("R4", {31'd0, sda_o}, {31'd0, (hc < 4) ? cur[1] : cur[0]}, "SDA while SCL high");
          hc++;
        end
      end
      prev_scl = scl_o;
    end
  end

  task automatic q_start(); exp_q.push_back(2'b10); slv_q.push_back(1'b1); endtask
  task automatic q_stop();  exp_q.push_back(2'b01); slv_q.push_back(1'b1); endtask

  task automatic q_out(input logic [7:0] b, input bit ack, input int arb_bit, output bit lost);
    lost = 0;
    for (int i = 7; i >= 0; i--) begin
      exp_q.push_back({b[i], b[i]});
      if (i == arb_bit && b[i]) begin slv_q.push_back(1'b0); lost = 1; return; end
      slv_q.push_back(1'b1);
    end
    exp_q.push_back(2'b11); slv_q.push_back(ack ? 1'b0 : 1'b1);
  endtask

  task automatic q_in(input logic [7:0] d, input bit last);
    for (int i = 7; i >= 0; i--) begin exp_q.push_back(2'b11); slv_q.push_back(d[i]); end
    exp_q.push_back(last ? 2'b11 : 2'b00); slv_q.push_back(1'b1);
  endtask

  function automatic logic [7:0] txb(input int i); return 8'hA5 + 8'(i * 7); endfunction
  function automatic logic [7:0] rxb(input int i); return 8'h3C ^ 8'(i * 8'h11); endfunction

  // kind: 0 done_stop, 1 done_nostop, 2 abort
  task automatic run_txn(input bit rd, input bit ten, input logic [9:0] adr, input bit stp,
                         input int len, input bit sb, input int nack_at, input int arb_at,
                         input int arb_bit, input string tag);
    logic [7:0] hdr[$];
    logic [7:0] exp_rx[$];
    bit lost = 0, ended = 0;
    int k = 0, cnt = 0, kind = 0, cause = 0, st_code = 2, tx_used = 0, wd = 0;
    logic [2:0] got_kind = 3'b000;
    bit busy_bad = 0;
    exp_q.delete(); slv_q.delete(); txq.delete(); got_q.delete();
    if (!rd) for (int i = 0; i < len; i++) txq.push_back(txb(i));
    q_start();
    if (ten) begin
      hdr.push_back({5'b11110, adr[9:8], 1'b0}); hdr.push_back(adr[7:0]);
      if (rd) begin hdr.push_back(8'h00); hdr.push_back({5'b11110, adr[9:8], 1'b1}); end
    end else hdr.push_back({adr[6:0], rd});
    for (int h = 0; h < hdr.size() && !ended; h++) begin
      if (ten && rd && h == 2) begin q_start(); continue; end
      q_out(hdr[h], k != nack_at, (k == arb_at) ? arb_bit : -1, lost);
      if (lost) begin ended = 1; kind = 2; cause = 3; st_code = 3; end
      else if (k == nack_at) begin q_stop(); ended = 1; kind = 2; cause = 0; st_code = 3; end
      k++;
    end
    for (int i = 0; i < len && !ended; i++) begin
      if (!rd) begin
        tx_used++;
        q_out(txb(i), k != nack_at, -1, lost);
        if (k == nack_at) begin q_stop(); ended = 1; kind = 2; cause = 1; st_code = 3; end
        else cnt++;
        k++;
      end else begin
        q_in(rxb(i), i == len - 1); exp_rx.push_back(rxb(i)); cnt++;
      end
    end
    if (!ended) begin
      if (stp) begin q_stop(); kind = 0; end else kind = 1;
    end
    @(negedge clk);
    cmd_word = {6'd0, 11'(len), stp, ten ? 2'b10 : 2'b01, sb, adr[9:7], adr[6:0], rd};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11", {31'd0, cmd_ready}, 32'd0, {tag, " ready while busy"});
    chk("R10", {30'd0, status[3:2]}, 32'd1, {tag, " ongoing state"});
    while (1) begin
      if (done_stop || done_nostop || abort_o) begin got_kind = {abort_o, done_nostop, done_stop}; break; end
      if (cmd_ready) busy_bad = 1;
      wd++;
      if (wd > 20000) begin chk("R13", 32'd0, 32'd1, {tag, " watchdog"}); break; end
      @(negedge clk);
    end
    chk("R11", {31'd0, busy_bad}, 32'd0, {tag, " ready during transaction"});
    chk("R13", {29'd0, got_kind}, 32'd1 << kind, {tag, " completion pulse"});
    chk("R10", status, {12'd0, 11'(cnt), 2'b00, 3'(cause), 2'(st_code), 1'b0, rd}, {tag, " status word"});
    @(negedge clk);
    chk("R13", {29'd0, abort_o, done_nostop, done_stop}, 32'd0, {tag, " pulse one cycle"});
    chk("R4", exp_q.size(), 32'd0, {tag, " SCL pulses left"});
    if (rd) begin
      chk("R6", got_q.size(), exp_rx.size(), {tag, " rx byte count"});
      for (int i = 0; i < got_q.size() && i < exp_rx.size(); i++)
        chk("R6", {24'd0, got_q[i]}, {24'd0, exp_rx[i]}, {tag, " rx byte"});
    end else begin
      chk("R5", len - txq.size(), tx_used, {tag, " tx bytes taken"});
    end
    if (kind == 1) chk("R7", {30'd0, scl_o, sda_o}, 32'd1, {tag, " parked lines"});
    if (kind != 1) chk("R9", {30'd0, scl_o, sda_o}, 32'd3, {tag, " released lines"});
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", status, 32'd0, "reset status");
    chk("R11", {31'd0, cmd_ready}, 32'd1, "reset ready");
    chk("R4", {30'd0, scl_o, sda_o}, 32'd3, "reset lines released");
    chk("R5", {31'd0, tx_ready}, 32'd0, "reset tx_ready");
    chk("R6", {31'd0, rx_valid}, 32'd0, "reset rx_valid");
    // R1 R2 R5 R7: 7-bit write with stop
    run_txn(0, 0, 10'h050, 1, 3, 0, -1, -1, -1, "w7");
    // R6: 7-bit read, ACK all but last
    run_txn(1, 0, 10'h02B, 1, 4, 0, -1, -1, -1, "r7");
    // R7: no-stop write, then repeated start read of one byte
    run_txn(0, 0, 10'h011, 0, 2, 0, -1, -1, -1, "w7_nostop");
    run_txn(1, 0, 10'h011, 1, 1, 0, -1, -1, -1, "r7_rstart");
    // R3: 10-bit write and read
    run_txn(0, 1, 10'h2B7, 1, 2, 0, -1, -1, -1, "w10");
    run_txn(1, 1, 10'h1C4, 1, 2, 0, -1, -1, -1, "r10");
    // R8: address NACK, then data NACK on second data byte
    run_txn(0, 0, 10'h044, 1, 2, 0, 0, -1, -1, "addr_nack");
    run_txn(0, 0, 10'h044, 1, 3, 0, 2, -1, -1, "data_nack");
    // R9: arbitration lost on address MSB
    run_txn(0, 0, 10'h055, 1, 2, 0, -1, 0, 7, "arb");
    // R12 and R1 (start-byte bit set): zero length write
    run_txn(0, 0, 10'h033, 1, 0, 1, -1, -1, -1, "len0");
    // R9 on 10-bit low address byte
    run_txn(1, 1, 10'h0F0, 1, 1, 0, -1, 1, 4, "arb10");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule